// File: doc/BRIEF.md
# Port Scan Dwell Sequencer

This block selects which of several modem ports a shared receive multiplexer listens to. It keeps a current port index and moves it forward in ascending order, wrapping from the highest port back to port 0. It has two ways of moving the index. In manual mode, a step pulse or a direct select write moves it. In the automatic modes, it moves on its own once the port has been watched for a set dwell time.

The dwell time is counted in bit periods, the length of one on-off-keyed bit at the configured data rate. A one-cycle strobe, `bit_tick`, marks each bit period. The automatic modes offer a single period, sixteen periods, or a custom length of 1 to 4096 periods. The custom length is held in a register that a load strobe writes. Out of reset it holds 81 periods. That is enough time to hear a complete ping message: ten 8-bit words followed by a stop bit.

When a dwell expires, the block pulses `dwell_done` for one cycle, and the port index steps on the next clock edge. Any change of mode, and any custom load, starts the dwell count again on the current port.

Top module: `port_scan_seq`

## Requirements
- R1: After reset, `port_idx` is 0 and `dwell_done` is 0. The custom dwell register holds 80, which selects 81 bit periods.
- R2: `scan_mode` encodes 0 as manual, 1 as a dwell of one bit period, 2 as a dwell of sixteen bit periods, and 3 as the custom dwell.
- R3: In an automatic mode with `scan_en` high, `dwell_done` is high for the cycle after the clock edge that samples the Nth `bit_tick` since the last restart. `port_idx` advances on the following edge.
- R4: The port index advances 0, 1, 2, 3 and then wraps back to 0. This holds for both manual steps and automatic advances.
- R5: A `cust_we` pulse loads `cust_dwell`, which encodes the period count minus one. A value of 0 gives 1 period and a value of 4095 gives 4096 periods.
- R6: In manual mode with `scan_en` high, `sel_we` loads `sel_port` and `step` advances the index. `sel_we` wins when both are high in the same cycle. Bit ticks never advance the index and never raise `dwell_done` in this mode.
- R7: In the automatic modes, `step` and `sel_we` have no effect on `port_idx`.
- R8: When `scan_mode` differs from its value in the previous cycle, or when `cust_we` is high, the dwell count restarts from zero on the current port. A tick in that same cycle is not counted.
- R9: While `scan_en` is low, `port_idx` holds (apart from completing an advance whose `dwell_done` is already showing), commands are ignored, no `dwell_done` is raised, and the dwell count is cleared.
- R10: Only cycles in which `bit_tick` is high count toward the dwell. Idle cycles between ticks neither count nor reset the dwell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | Enables scanning and manual commands |
| bit_tick | input | 1 | One-cycle strobe, one per bit period |
| scan_mode | input | 2 | Mode: 0 manual, 1 one period, 2 sixteen periods, 3 custom |
| cust_we | input | 1 | Load strobe for the custom dwell |
| cust_dwell | input | 12 | Custom dwell, period count minus one |
| step | input | 1 | Manual advance to the next port |
| sel_we | input | 1 | Manual direct select strobe |
| sel_port | input | 2 | Port loaded by `sel_we` |
| port_idx | output | 2 | Current port index |
| dwell_done | output | 1 | One-cycle pulse when a dwell expires |

## Verification
Each result has a fixed delay from its stimulus:
- A manual command changes `port_idx` at the first clock edge after it is driven.
- `dwell_done` rises at the edge that samples the expiring tick.
- The automatic index change appears one edge later.

The bench drives every input at the falling edge and, in the same step, queues the outputs expected after the next rising edge. A monitor compares them a quarter period after that rising edge, so each comparison lands in the exact cycle where the requirement places the change. The boundary runs are placed so that any early or late expiry would show up as a mismatch:
- single and sixteen periods with irregular gaps between ticks;
- the default 81;
- custom values 0 and 4095;
- a mid-dwell restart.

// File: rtl/psq_pkg.sv
package psq_pkg;

    typedef enum logic [1:0] {
        SCAN_MANUAL = 2'd0,
        SCAN_DW_ONE = 2'd1,
        SCAN_DW_MID = 2'd2,
        SCAN_DW_CUS = 2'd3
    } scan_mode_e;

endpackage

// File: rtl/psq_limit.sv
// Picks the terminal count (periods minus one) for the active dwell mode.
module psq_limit #(
    parameter int CNT_W     = 12,
    parameter int MID_DWELL = 16
) (
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] cust,
    output logic [CNT_W-1:0] limit
);
    import psq_pkg::*;

    localparam logic [CNT_W-1:0] MID_LIMIT = CNT_W'(MID_DWELL - 1);

    always_comb begin
        case (scan_mode_e'(mode))
            SCAN_DW_ONE: limit = '0;
            SCAN_DW_MID: limit = MID_LIMIT;
            SCAN_DW_CUS: limit = cust;
            default:     limit = '0;
        endcase
    end

endmodule

// File: rtl/psq_dwell_cnt.sv
// Counts bit ticks on the current port and flags expiry for one cycle.
module psq_dwell_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!run || restart) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == limit) begin
                st_d.cnt  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expire = st_q.done;

endmodule

// File: rtl/psq_port_ptr.sv
// Holds the port index; automatic advance outranks direct select, which outranks step.
module psq_port_ptr #(
    parameter int NUM_PORTS = 4,
    parameter int PW        = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    input  logic          step,
    output logic [PW-1:0] port
);
    localparam logic [PW-1:0] LAST = PW'(NUM_PORTS - 1);

    typedef struct packed {
        logic [PW-1:0] idx;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [PW-1:0] next_idx;

    always_comb begin
        next_idx = (st_q.idx == LAST) ? '0 : st_q.idx + 1'b1;
        st_d     = st_q;
        if (adv)       st_d.idx = next_idx;
        else if (load) st_d.idx = load_val;
        else if (step) st_d.idx = next_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign port = st_q.idx;

endmodule

// File: rtl/port_scan_seq.sv
module port_scan_seq #(
    parameter int NUM_PORTS = 4,
    parameter int CNT_W     = 12,
    parameter int MID_DWELL = 16,
    parameter int CUST_RST  = 81,
    localparam int PW       = (NUM_PORTS > 2) ? $clog2(NUM_PORTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic             bit_tick,
    input  logic [1:0]       scan_mode,
    input  logic             cust_we,
    input  logic [CNT_W-1:0] cust_dwell,
    input  logic             step,
    input  logic             sel_we,
    input  logic [PW-1:0]    sel_port,
    output logic [PW-1:0]    port_idx,
    output logic             dwell_done
);
    import psq_pkg::*;

    localparam logic [CNT_W-1:0] CUST_RST_ENC = CNT_W'(CUST_RST - 1);

    typedef struct packed {
        logic [1:0]       mode;
        logic [CNT_W-1:0] cust;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;
    logic             restart;
    logic             run;
    logic             manual_ok;
    logic [CNT_W-1:0] limit;
    logic             expire;

    always_comb begin
        cfg_d      = cfg_q;
        cfg_d.mode = scan_mode;
        if (cust_we) cfg_d.cust = cust_dwell;
        restart   = (scan_mode != cfg_q.mode) || cust_we;
        run       = scan_en && (scan_mode_e'(scan_mode) != SCAN_MANUAL);
        manual_ok = scan_en && (scan_mode_e'(scan_mode) == SCAN_MANUAL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mode <= SCAN_MANUAL;
            cfg_q.cust <= CUST_RST_ENC;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    psq_limit #(.CNT_W(CNT_W), .MID_DWELL(MID_DWELL)) u_limit (
        .mode  (scan_mode),
        .cust  (cfg_q.cust),
        .limit (limit)
    );

    psq_dwell_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .tick    (bit_tick),
        .limit   (limit),
        .expire  (expire)
    );

    psq_port_ptr #(.NUM_PORTS(NUM_PORTS), .PW(PW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (expire),
        .load     (manual_ok && sel_we),
        .load_val (sel_port),
        .step     (manual_ok && step),
        .port     (port_idx)
    );

    assign dwell_done = expire;

endmodule

// File: rtl/psq_checker.sv
module psq_checker #(
    parameter int NUM_PORTS = 4,
    parameter int PW        = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scan_en,
    input logic          bit_tick,
    input logic [1:0]    scan_mode,
    input logic [PW-1:0] port_idx,
    input logic          dwell_done
);
    localparam logic [PW-1:0] LAST = PW'(NUM_PORTS - 1);

    // R3: an expiry is followed by an advance to the next port
    p_advance_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dwell_done && port_idx != LAST) |=> port_idx == $past(port_idx) + 1'b1);

    // R4: an expiry on the last port wraps to port 0
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dwell_done && port_idx == LAST) |=> port_idx == '0);

    // R10: expiry only follows an enabled tick in an automatic mode
    p_done_needs_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dwell_done |-> $past(bit_tick && scan_en && scan_mode != 2'd0));

    // R6: manual mode never produces an expiry
    p_manual_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_mode == 2'd0) |=> !dwell_done);

    // R7: automatic modes ignore manual commands
    p_auto_ignores_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && scan_mode != 2'd0 && !dwell_done) |=> $stable(port_idx));

    // R9: disabled scanning holds the index
    p_hold_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !dwell_done) |=> $stable(port_idx));

endmodule

bind port_scan_seq psq_checker #(.NUM_PORTS(NUM_PORTS), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_en    (scan_en),
    .bit_tick   (bit_tick),
    .scan_mode  (scan_mode),
    .port_idx   (port_idx),
    .dwell_done (dwell_done)
);

// File: tb/tb_port_scan_seq.sv
module tb_port_scan_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_en = 1'b0;
    logic        bit_tick = 1'b0;
    logic [1:0]  scan_mode = 2'd0;
    logic        cust_we = 1'b0;
    logic [11:0] cust_dwell = '0;
    logic        step = 1'b0;
    logic        sel_we = 1'b0;
    logic [1:0]  sel_port = '0;
    logic [1:0]  port_idx;
    logic        dwell_done;

    port_scan_seq dut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .bit_tick(bit_tick),
        .scan_mode(scan_mode), .cust_we(cust_we), .cust_dwell(cust_dwell),
        .step(step), .sel_we(sel_we), .sel_port(sel_port),
        .port_idx(port_idx), .dwell_done(dwell_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [1:0] port;
        logic       done;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 1'b0;

    // staged stimulus
    logic        s_en = 1'b0, s_tick = 1'b0, s_cust_we = 1'b0, s_step = 1'b0, s_sel_we = 1'b0;
    logic [1:0]  s_mode = 2'd0, s_sel = 2'd0;
    logic [11:0] s_cust = '0;

    // expectation model from the requirements
    logic [1:0]  m_port = 2'd0, m_mode = 2'd0;
    logic [11:0] m_cnt = '0, m_cust = 12'd80;
    logic        m_done = 1'b0;

    task automatic go(input string tag);
        exp_t e;
        logic restart, run, nd;
        logic [11:0] lim, nc;
        logic [1:0]  np;
        @(negedge clk);
        scan_en = s_en; bit_tick = s_tick; scan_mode = s_mode; cust_we = s_cust_we;
        cust_dwell = s_cust; step = s_step; sel_we = s_sel_we; sel_port = s_sel;
        restart = (s_mode != m_mode) || s_cust_we;
        run = s_en && (s_mode != 2'd0);
        lim = (s_mode == 2'd1) ? 12'd0 : (s_mode == 2'd2) ? 12'd15 : m_cust;
        nd = 1'b0; nc = m_cnt;
        if (!run || restart) nc = '0;
        else if (s_tick) begin
            if (m_cnt == lim) begin nc = '0; nd = 1'b1; end
            else nc = m_cnt + 12'd1;
        end
        np = m_port;
        if (m_done) np = m_port + 2'd1;
        else if (s_en && s_mode == 2'd0 && s_sel_we) np = s_sel;
        else if (s_en && s_mode == 2'd0 && s_step) np = m_port + 2'd1;
        m_port = np; m_cnt = nc; m_done = nd; m_mode = s_mode;
        if (s_cust_we) m_cust = s_cust;
        e.port = np; e.done = nd; e.tag = tag;
        exp_q.push_back(e);
        s_tick = 1'b0; s_step = 1'b0; s_sel_we = 1'b0; s_cust_we = 1'b0;
    endtask

    task automatic ticks(input int n, input int gap, input string tag);
        for (int i = 0; i < n; i++) begin
            s_tick = 1'b1;
            go(tag);
            for (int g = 0; g < ((gap < 0) ? (i % 3) : gap); g++) go(tag);
        end
        go(tag);
        go(tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (port_idx !== e.port || dwell_done !== e.done) begin
                    n_fails++;
                    $display("FAIL %s: port=%0d done=%0d expected port=%0d done=%0d",
                             e.tag, port_idx, dwell_done, e.port, e.done);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        n_checks++;
        if (port_idx !== 2'd0 || dwell_done !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 reset: port=%0d done=%0d expected port=0 done=0", port_idx, dwell_done);
        end

        // manual mode
        s_en = 1'b1; s_mode = 2'd0;
        go("R1 idle after reset");
        for (int i = 0; i < 5; i++) begin s_step = 1'b1; go("R6 R4 manual step and wrap"); end
        s_sel_we = 1'b1; s_sel = 2'd2; go("R6 direct select");
        s_sel_we = 1'b1; s_sel = 2'd0; s_step = 1'b1; go("R6 select beats step");
        for (int i = 0; i < 20; i++) begin s_tick = 1'b1; go("R6 ticks ignored in manual"); end

        // one-period dwell with gaps
        s_mode = 2'd1; go("R2 R8 switch to one period");
        for (int i = 0; i < 6; i++) begin s_tick = 1'b1; go("R2 R3 one period"); go("R3 R4 advance"); end

        // sixteen periods with irregular idle gaps
        s_mode = 2'd2; go("R2 switch to sixteen");
        ticks(16, -1, "R2 R10 sixteen with gaps");

        // default custom of 81
        s_mode = 2'd3; go("R8 switch to custom");
        ticks(81, 0, "R1 R5 default 81");

        // restart mid-dwell by a custom load
        s_mode = 2'd2; go("R8 back to sixteen");
        ticks(10, 0, "R8 partial dwell");
        s_cust_we = 1'b1; s_cust = 12'd4; s_tick = 1'b1; go("R8 load restarts count");
        ticks(16, 1, "R8 full sixteen after restart");

        // custom of 5 with manual commands that must be ignored
        s_mode = 2'd3; go("R8 custom of five");
        for (int i = 0; i < 12; i++) begin
            s_tick = 1'b1; s_step = 1'b1; s_sel_we = 1'b1; s_sel = 2'd3;
            go("R7 R5 commands ignored in auto");
            s_step = 1'b1; go("R7 step ignored in auto");
        end

        // custom 0 means one period
        s_cust_we = 1'b1; s_cust = 12'd0; go("R5 load zero");
        ticks(4, 1, "R5 custom one period");

        // disabled
        s_en = 1'b0;
        for (int i = 0; i < 20; i++) begin s_tick = 1'b1; s_step = 1'b1; go("R9 disabled holds"); end
        s_mode = 2'd0;
        for (int i = 0; i < 4; i++) begin s_step = 1'b1; s_sel_we = 1'b1; s_sel = 2'd1; go("R9 disabled manual ignored"); end
        s_en = 1'b1; s_mode = 2'd3;
        s_cust_we = 1'b1; s_cust = 12'd4095; go("R5 load maximum");
        ticks(4096, 0, "R5 maximum 4096");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule